// File: doc/BRIEF.md
# Floating-Point Multi-Register Transfer Sequencer

This block turns one floating-point load-multiple or store-multiple request into a series of single-word memory micro-ops. It issues one micro-op per cycle over a valid/ready handshake. A request is a one-cycle start pulse with these fields: the transfer kind, the element size, the address direction, a base-update flag, a base register, the first floating-point register, an element count and a word offset. Each micro-op carries:

- its kind
- its target floating-point register
- its base register
- a direction flag
- an unsigned byte displacement
- a last marker

Micro-ops can only carry unsigned displacements. A descending transfer therefore starts at a positive byte displacement and counts down toward zero. Once it reaches zero, it continues as an ascending transfer from there. An optional base-update micro-op closes the series. The block reports how many micro-ops the current request produces. It has no memory port, no register-file port and no data path.

Top module: `fp_xfer_seq`

## Requirements
- R1: After an accepted start, `uop_total_o` equals the clamped element count times 1 (single) or 2 (double), plus 1 when the base update is requested. It holds that value until the next accepted start.
- R2: An element count above `NUM_FP_REGS` is treated as `NUM_FP_REGS`.
- R3: Data micro-ops carry kind 0 for a load and kind 1 for a store, and base register `base_i`. Their register is `freg_i` plus the micro-op's position (starting at 0), modulo 2^FREG_W.
- R4: In ascending mode (`up_i`=1) the first element sits at displacement 0. Each following element sits 4 (single) or 8 (double) bytes higher. A double element issues two micro-ops, at d and d+4. The direction flag is 1.
- R5: In descending mode the first element sits at 4 × `ofs_i`, with no wrap for any offset value. Each following element sits 4 or 8 bytes lower, and the direction flag is 0. When the stepped displacement becomes exactly zero, every later data micro-op has direction flag 1 and steps upward as in R4.
- R6: With base update requested, the final micro-op has kind 2 and the requested direction. Its displacement is the number of bytes moved: clamped count × 4 or × 8.
- R7: `uop_last_o` is 1 on the final micro-op of a series and 0 on every other one.
- R8: While `uop_valid_o` is 1 and `uop_ready_i` is 0, all micro-op fields hold steady. Each accepted handshake advances by exactly one micro-op.
- R9: `busy_o` is 1 from the cycle after an accepted start until the final micro-op is accepted. A start while busy is ignored.
- R10: `done_o` pulses for one cycle after the final micro-op is accepted. A request with zero elements and no base update issues no micro-op, never raises `busy_o`, and pulses `done_o` in the cycle after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse |
| load_i | input | 1 | 1 load, 0 store |
| dbl_i | input | 1 | 1 double (two words per element), 0 single |
| up_i | input | 1 | 1 ascending, 0 descending |
| wb_i | input | 1 | Append base-update micro-op |
| base_i | input | BREG_W | Base register index |
| freg_i | input | FREG_W | First floating-point register index |
| cnt_i | input | CNT_W | Requested element count |
| ofs_i | input | OFS_W | Word offset for descending start |
| uop_valid_o | output | 1 | Micro-op valid |
| uop_ready_i | input | 1 | Micro-op accepted |
| uop_kind_o | output | 2 | 0 load, 1 store, 2 base update |
| uop_freg_o | output | FREG_W | Target floating-point register |
| uop_base_o | output | BREG_W | Base register |
| uop_up_o | output | 1 | Direction flag |
| uop_disp_o | output | DISP_W | Unsigned byte displacement |
| uop_last_o | output | 1 | Final micro-op marker |
| uop_total_o | output | TOT_W | Micro-op count of the current request |
| busy_o | output | 1 | Series in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench uses the default parameters: 32 registers, 6-bit register index, 8-bit count and 8-bit offset.

- A count of 40 reaches the clamp. A double series of that size produces 65 micro-ops and walks the register index through its wrap.
- An offset of 255 reaches the top of the 10-bit displacement range, 1020 bytes, without overflow.
- Small descending offsets against larger counts reach the zero-crossing switch to ascending mode mid-series.

Intermittent ready stalls check that fields hold while the consumer stalls.

// File: rtl/fp_xfer_pkg.sv
package fp_xfer_pkg;
  typedef enum logic [1:0] {
    UOP_LOAD  = 2'd0,
    UOP_STORE = 2'd1,
    UOP_WBACK = 2'd2
  } uop_kind_e;
endpackage

// File: rtl/fp_xfer_count.sv
module fp_xfer_count #(
  parameter int NUM_FP_REGS = 32,
  parameter int CNT_W       = 8,
  parameter int TOT_W       = 7,
  parameter int DISP_W      = 10
) (
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              dbl_i,
  input  logic              wb_i,
  output logic [TOT_W-1:0]  total_o,
  output logic [DISP_W-1:0] bytes_o
);
  localparam int E_W = $clog2(NUM_FP_REGS + 1);

  logic [E_W-1:0]   elem;
  logic [TOT_W-1:0] data_cnt;

  always_comb begin
    elem     = (cnt_i > CNT_W'(NUM_FP_REGS)) ? E_W'(NUM_FP_REGS) : E_W'(cnt_i);
    data_cnt = dbl_i ? TOT_W'({elem, 1'b0}) : TOT_W'(elem);
    total_o  = data_cnt + TOT_W'(wb_i);
    bytes_o  = dbl_i ? DISP_W'({elem, 3'b000}) : DISP_W'({elem, 2'b00});
  end
endmodule

// File: rtl/fp_xfer_addr.sv
module fp_xfer_addr #(
  parameter int OFS_W  = 8,
  parameter int DISP_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              up_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic              dbl_i,
  input  logic              step_i,
  output logic [DISP_W-1:0] disp_o,
  output logic              up_o
);
  logic [DISP_W-1:0] disp_q, step, dn_nxt;
  logic              up_q;

  assign step   = dbl_i ? DISP_W'(8) : DISP_W'(4);
  assign dn_nxt = disp_q - step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_q <= '0;
      up_q   <= 1'b1;
    end else if (load_i) begin
      disp_q <= up_i ? '0 : DISP_W'({ofs_i, 2'b00});
      up_q   <= up_i;
    end else if (step_i) begin
      if (up_q) begin
        disp_q <= disp_q + step;
      end else begin
        disp_q <= dn_nxt;
        // unsigned displacement only: turn around at zero
        if (dn_nxt == '0) up_q <= 1'b1;
      end
    end
  end

  assign disp_o = disp_q;
  assign up_o   = up_q;
endmodule

// File: rtl/fp_xfer_ctrl.sv
module fp_xfer_ctrl
  import fp_xfer_pkg::*;
#(
  parameter int FREG_W = 6,
  parameter int BREG_W = 4,
  parameter int TOT_W  = 7,
  parameter int DISP_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              load_i,
  input  logic              dbl_i,
  input  logic              up_i,
  input  logic              wb_i,
  input  logic [BREG_W-1:0] base_i,
  input  logic [FREG_W-1:0] freg_i,
  input  logic [TOT_W-1:0]  total_i,
  input  logic [DISP_W-1:0] bytes_i,
  input  logic [DISP_W-1:0] elem_disp_i,
  input  logic              elem_up_i,
  input  logic              ready_i,
  output logic              addr_load_o,
  output logic              addr_step_o,
  output logic              dbl_o,
  output logic              valid_o,
  output logic [1:0]        kind_o,
  output logic [FREG_W-1:0] freg_o,
  output logic [BREG_W-1:0] base_o,
  output logic              up_o,
  output logic [DISP_W-1:0] disp_o,
  output logic              last_o,
  output logic [TOT_W-1:0]  total_o,
  output logic              busy_o,
  output logic              done_o
);
  logic              busy_q, done_q, ld_q, dbl_q, wb_q, up_q;
  logic [BREG_W-1:0] base_q;
  logic [FREG_W-1:0] freg_q;
  logic [TOT_W-1:0]  total_q, idx_q;
  logic [DISP_W-1:0] bytes_q;
  logic              accept, fire, last, is_wb, half;
  uop_kind_e         kind;

  assign accept = start_i && !busy_q;
  assign fire   = busy_q && ready_i;
  assign last   = (idx_q == total_q - TOT_W'(1));
  assign is_wb  = wb_q && last;
  assign half   = dbl_q && idx_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      ld_q    <= 1'b0;
      dbl_q   <= 1'b0;
      wb_q    <= 1'b0;
      up_q    <= 1'b0;
      base_q  <= '0;
      freg_q  <= '0;
      total_q <= '0;
      idx_q   <= '0;
      bytes_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        ld_q    <= load_i;
        dbl_q   <= dbl_i;
        wb_q    <= wb_i;
        up_q    <= up_i;
        base_q  <= base_i;
        freg_q  <= freg_i;
        total_q <= total_i;
        bytes_q <= bytes_i;
        idx_q   <= '0;
        busy_q  <= (total_i != '0);
        done_q  <= (total_i == '0);
      end else if (fire) begin
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + TOT_W'(1);
        end
      end
    end
  end

  always_comb begin
    if (is_wb)     kind = UOP_WBACK;
    else if (ld_q) kind = UOP_LOAD;
    else           kind = UOP_STORE;
  end

  assign addr_load_o = accept;
  assign addr_step_o = fire && !is_wb && (!dbl_q || idx_q[0]);
  assign dbl_o       = dbl_q;
  assign valid_o     = busy_q;
  assign kind_o      = kind;
  assign freg_o      = is_wb ? '0 : freg_q + FREG_W'(idx_q);
  assign base_o      = base_q;
  assign up_o        = is_wb ? up_q : elem_up_i;
  assign disp_o      = is_wb ? bytes_q : elem_disp_i + (half ? DISP_W'(4) : '0);
  assign last_o      = busy_q && last;
  assign total_o     = total_q;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
endmodule

// File: rtl/fp_xfer_seq.sv
module fp_xfer_seq #(
  parameter int NUM_FP_REGS = 32,
  parameter int FREG_W      = 6,
  parameter int BREG_W      = 4,
  parameter int CNT_W       = 8,
  parameter int OFS_W       = 8,
  localparam int TOT_W      = $clog2(2 * NUM_FP_REGS + 2),
  localparam int BYTE_W     = $clog2(NUM_FP_REGS * 8 + 1),
  localparam int DISP_W     = (OFS_W + 2 > BYTE_W) ? OFS_W + 2 : BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              load_i,
  input  logic              dbl_i,
  input  logic              up_i,
  input  logic              wb_i,
  input  logic [BREG_W-1:0] base_i,
  input  logic [FREG_W-1:0] freg_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [OFS_W-1:0]  ofs_i,
  output logic              uop_valid_o,
  input  logic              uop_ready_i,
  output logic [1:0]        uop_kind_o,
  output logic [FREG_W-1:0] uop_freg_o,
  output logic [BREG_W-1:0] uop_base_o,
  output logic              uop_up_o,
  output logic [DISP_W-1:0] uop_disp_o,
  output logic              uop_last_o,
  output logic [TOT_W-1:0]  uop_total_o,
  output logic              busy_o,
  output logic              done_o
);
  logic [TOT_W-1:0]  total;
  logic [DISP_W-1:0] bytes, elem_disp;
  logic              elem_up, addr_load, addr_step, dbl_q;

  fp_xfer_count #(
    .NUM_FP_REGS(NUM_FP_REGS), .CNT_W(CNT_W), .TOT_W(TOT_W), .DISP_W(DISP_W)
  ) u_count (
    .cnt_i(cnt_i), .dbl_i(dbl_i), .wb_i(wb_i), .total_o(total), .bytes_o(bytes)
  );

  fp_xfer_addr #(.OFS_W(OFS_W), .DISP_W(DISP_W)) u_addr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(addr_load), .up_i(up_i),
    .ofs_i(ofs_i), .dbl_i(dbl_q), .step_i(addr_step),
    .disp_o(elem_disp), .up_o(elem_up)
  );

  fp_xfer_ctrl #(
    .FREG_W(FREG_W), .BREG_W(BREG_W), .TOT_W(TOT_W), .DISP_W(DISP_W)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .load_i(load_i),
    .dbl_i(dbl_i), .up_i(up_i), .wb_i(wb_i), .base_i(base_i), .freg_i(freg_i),
    .total_i(total), .bytes_i(bytes), .elem_disp_i(elem_disp), .elem_up_i(elem_up),
    .ready_i(uop_ready_i), .addr_load_o(addr_load), .addr_step_o(addr_step),
    .dbl_o(dbl_q), .valid_o(uop_valid_o), .kind_o(uop_kind_o),
    .freg_o(uop_freg_o), .base_o(uop_base_o), .up_o(uop_up_o),
    .disp_o(uop_disp_o), .last_o(uop_last_o), .total_o(uop_total_o),
    .busy_o(busy_o), .done_o(done_o)
  );
endmodule

// File: rtl/fp_xfer_seq_chk.sv
module fp_xfer_seq_chk #(
  parameter int NUM_FP_REGS = 32,
  parameter int FREG_W      = 6,
  parameter int TOT_W       = 7,
  parameter int DISP_W      = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              uop_ready_i,
  input logic              uop_valid_o,
  input logic [1:0]        uop_kind_o,
  input logic [FREG_W-1:0] uop_freg_o,
  input logic              uop_up_o,
  input logic [DISP_W-1:0] uop_disp_o,
  input logic              uop_last_o,
  input logic [TOT_W-1:0]  uop_total_o,
  input logic              busy_o,
  input logic              done_o
);
  a_r8_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o && !uop_ready_i |=> uop_valid_o && $stable(uop_kind_o) &&
      $stable(uop_freg_o) && $stable(uop_up_o) && $stable(uop_disp_o) && $stable(uop_last_o));

  a_r10_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o && uop_ready_i && uop_last_o |=> done_o && !busy_o);

  a_r9_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && !(uop_valid_o && uop_ready_i && uop_last_o) |=> $stable(uop_total_o));

  a_r2_total_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_total_o <= TOT_W'(2 * NUM_FP_REGS + 1));

  a_r5_up_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o && uop_ready_i && !uop_last_o && uop_up_o && uop_kind_o != 2'd2
      |=> uop_kind_o == 2'd2 || uop_up_o);

  a_r10_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !uop_valid_o);
endmodule

bind fp_xfer_seq fp_xfer_seq_chk #(
  .NUM_FP_REGS(NUM_FP_REGS), .FREG_W(FREG_W), .TOT_W(TOT_W), .DISP_W(DISP_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .uop_ready_i(uop_ready_i),
  .uop_valid_o(uop_valid_o), .uop_kind_o(uop_kind_o), .uop_freg_o(uop_freg_o),
  .uop_up_o(uop_up_o), .uop_disp_o(uop_disp_o), .uop_last_o(uop_last_o),
  .uop_total_o(uop_total_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/fp_xfer_seq_tb.sv
`timescale 1ns/1ps
module fp_xfer_seq_tb;
  localparam int NREG = 32;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 0, load_i = 0, dbl_i = 0, up_i = 0, wb_i = 0, uop_ready_i = 0;
  logic [3:0] base_i = '0;
  logic [5:0] freg_i = '0;
  logic [7:0] cnt_i = '0, ofs_i = '0;
  logic uop_valid_o, uop_up_o, uop_last_o, busy_o, done_o;
  logic [1:0] uop_kind_o;
  logic [5:0] uop_freg_o;
  logic [3:0] uop_base_o;
  logic [9:0] uop_disp_o;
  logic [6:0] uop_total_o;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  fp_xfer_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .load_i(load_i), .dbl_i(dbl_i),
    .up_i(up_i), .wb_i(wb_i), .base_i(base_i), .freg_i(freg_i), .cnt_i(cnt_i),
    .ofs_i(ofs_i), .uop_valid_o(uop_valid_o), .uop_ready_i(uop_ready_i),
    .uop_kind_o(uop_kind_o), .uop_freg_o(uop_freg_o), .uop_base_o(uop_base_o),
    .uop_up_o(uop_up_o), .uop_disp_o(uop_disp_o), .uop_last_o(uop_last_o),
    .uop_total_o(uop_total_o), .busy_o(busy_o), .done_o(done_o)
  );

  // {load, dbl, up, wb, cnt[7:0], ofs[7:0], exp_total[6:0]}
  localparam int NV = 8;
  localparam logic [26:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b1, 1'b0, 8'd4,  8'd0,   7'd4},
    {1'b0, 1'b1, 1'b1, 1'b1, 8'd3,  8'd0,   7'd7},
    {1'b1, 1'b1, 1'b0, 1'b1, 8'd2,  8'd4,   7'd5},
    {1'b0, 1'b0, 1'b0, 1'b0, 8'd4,  8'd2,   7'd4},
    {1'b1, 1'b0, 1'b0, 1'b1, 8'd3,  8'd3,   7'd4},
    {1'b0, 1'b1, 1'b1, 1'b1, 8'd40, 8'd0,   7'd65},
    {1'b1, 1'b0, 1'b1, 1'b1, 8'd0,  8'd0,   7'd1},
    {1'b1, 1'b0, 1'b0, 1'b0, 8'd1,  8'd255, 7'd1}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic pulse_start(input bit ld, dbl, up, wb, input int cnt, ofs, fr, bs);
    load_i = ld; dbl_i = dbl; up_i = up; wb_i = wb;
    cnt_i = 8'(cnt); ofs_i = 8'(ofs); freg_i = 6'(fr); base_i = 4'(bs);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Drives one request, checks every micro-op against a model built from R1-style rules.
  task automatic run_case(input bit ld, dbl, up, wb, input int cnt, ofs, exp_total,
                          input int fr, bs);
    int elem, ndata, total, m_disp, j, cyc;
    bit m_up;
    logic [22:0] exp_v, act_v;
    elem   = (cnt > NREG) ? NREG : cnt;
    ndata  = dbl ? 2 * elem : elem;
    total  = ndata + (wb ? 1 : 0);
    m_disp = up ? 0 : 4 * ofs;
    m_up   = up;
    pulse_start(ld, dbl, up, wb, cnt, ofs, fr, bs);
    chk(uop_total_o == 7'(exp_total) && total == exp_total, "R1 R2 total",
        uop_total_o, exp_total);
    chk(busy_o == (total != 0), "R9 busy after start", busy_o, total != 0);
    j = 0; cyc = 0;
    while (j < total && cyc < 2000) begin
      uop_ready_i = (cyc % 3) != 2;
      if (uop_valid_o && uop_ready_i) begin
        if (j < ndata) begin
          exp_v = {ld ? 2'd0 : 2'd1, 6'(fr + j), 4'(bs), m_up,
                   10'(m_disp + ((dbl && (j % 2 == 1)) ? 4 : 0)), j == total - 1};
        end else begin
          exp_v = {2'd2, 6'd0, 4'(bs), up, 10'(elem * (dbl ? 8 : 4)), 1'b1};
        end
        act_v = {uop_kind_o, uop_freg_o, uop_base_o, uop_up_o, uop_disp_o, uop_last_o};
        chk(act_v == exp_v, (j < ndata) ? "R3 R4 R5 R7 data uop" : "R6 R7 writeback uop",
            act_v, exp_v);
        if (j < ndata && (!dbl || (j % 2 == 1))) begin
          if (m_up) m_disp += dbl ? 8 : 4;
          else begin
            m_disp -= dbl ? 8 : 4;
            if (m_disp == 0) m_up = 1'b1;
          end
        end
        j++;
      end
      cyc++;
      @(negedge clk);
    end
    uop_ready_i = 1'b0;
    chk(j == total, "R8 uop count", j, total);
    chk(done_o && !busy_o && !uop_valid_o, "R10 done after last", {done_o, busy_o}, 2'b10);
    @(negedge clk);
    chk(!done_o, "R10 done single cycle", done_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!uop_valid_o && !busy_o && !done_o && uop_total_o == 0, "R9 reset state",
        {uop_valid_o, busy_o, done_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run_case(VEC[i][26], VEC[i][25], VEC[i][24], VEC[i][23], int'(VEC[i][22:15]),
               int'(VEC[i][14:7]), int'(VEC[i][6:0]), 3 * i + 1, i);
    end

    // R10: empty request
    pulse_start(1'b1, 1'b0, 1'b1, 1'b0, 0, 0, 0, 0);
    chk(done_o && !busy_o && !uop_valid_o, "R10 empty request", {done_o, busy_o, uop_valid_o}, 3'b100);
    @(negedge clk);
    chk(!done_o && !uop_valid_o, "R10 empty no uop", {done_o, uop_valid_o}, 0);

    // R9: start while busy is ignored; R8: stall holds first uop
    pulse_start(1'b0, 1'b0, 1'b1, 1'b0, 3, 0, 10, 2);
    @(negedge clk);
    pulse_start(1'b1, 1'b1, 1'b0, 1'b1, 5, 9, 20, 7);
    chk(uop_total_o == 7'd3 && uop_kind_o == 2'd1 && uop_freg_o == 6'd10 && uop_base_o == 4'd2,
        "R9 start ignored", {uop_total_o, uop_kind_o, uop_freg_o}, {7'd3, 2'd1, 6'd10});
    chk(uop_disp_o == 10'd0 && uop_valid_o, "R8 stalled uop held", uop_disp_o, 0);
    uop_ready_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      chk(uop_valid_o && uop_disp_o == 10'(4 * k) && uop_freg_o == 6'(10 + k),
          "R8 R4 one per accept", uop_disp_o, 4 * k);
      @(negedge clk);
    end
    uop_ready_i = 1'b0;
    chk(done_o && !busy_o, "R10 done after ignored start", {done_o, busy_o}, 2'b10);
    @(negedge clk);

    summary();
    $finish;
  end
endmodule